// File: doc/BRIEF.md
# Register Bank with Write-Lock Queue

This block is the register file of a pipelined processor whose write-backs finish well after the reads of later instructions. Each issuing instruction presents two source register numbers and one destination register number. When the instruction is accepted, both sources are read and the destination is appended to a first-in-first-out queue of pending writes. While a register number sits in any live queue entry, that register is locked, and an instruction that reads it is held at issue. Instructions whose sources are unlocked issue at once, however many writes are outstanding.

Write-backs come back in issue order. A write-back is taken only when it names the register at the head of the queue; it then updates the register and retires the head in the same cycle. Several pending writes to one register may sit in the queue together, and the register stays locked until the last of them retires. Hazards are found by comparing the sources against every live entry, with no arbitration between the read and write sides.

Top module: `regbank_wlq`

## Requirements
- R1: After reset every register reads as zero, the queue is empty, `iss_ready_o` is 1 and `rd_valid_o` is 0.
- R2: An issue is accepted in a cycle where `iss_valid_i` and `iss_ready_o` are both 1; its destination is then appended at the queue tail.
- R3: A source is locked when it equals the register number of any live queue entry, not counting the head entry retired by a write-back in the same cycle; duplicate entries keep a register locked until the last one retires, and `iss_ready_o` is 0 while either source is locked.
- R4: One cycle after an accepted issue, `rd_valid_o` is 1 and `rd_a_o`/`rd_b_o` hold the two source registers as of the accepting cycle, including a value written back in that same cycle; otherwise `rd_valid_o` is 0.
- R5: A write-back is taken when `wb_valid_i` is 1, the queue is non-empty and `wb_addr_i` equals the head entry; it writes `wb_data_i` and removes the head in the same cycle.
- R6: A write-back with an empty queue or a register number other than the head has no effect on any register or on the queue.
- R7: The queue holds 8 entries; with 8 live entries `iss_ready_o` is 0 unless a write-back is taken in that cycle.
- R8: A source that matches no live entry never holds issue, whatever number of writes is pending to other registers.
- R9: An instruction whose destination equals one of its sources reads the value before its own pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Instruction presented for issue |
| iss_ra_i | input | 4 | First source register |
| iss_rb_i | input | 4 | Second source register |
| iss_rw_i | input | 4 | Destination register to lock |
| iss_ready_o | output | 1 | Issue may proceed (room and no locked source) |
| rd_valid_o | output | 1 | Read results valid |
| rd_a_o | output | 32 | Value of first source |
| rd_b_o | output | 32 | Value of second source |
| wb_valid_i | input | 1 | Write-back presented |
| wb_addr_i | input | 4 | Write-back register |
| wb_data_i | input | 32 | Write-back value |

## Verification
A corrupted queue pointer or count shows up at `iss_ready_o` within a cycle or two, since the stall decision depends on exactly which entries are live; a lost or extra entry either releases a locked register early or keeps it stalled after its last write-back. A wrong register or bypass shows up on `rd_a_o`/`rd_b_o` the cycle after the next read of that register. Directed cases cover duplicate locks, a write-back retiring the last lock while the same register is read, a full queue and mismatched write-backs; random traffic over a narrow register range keeps hazards frequent.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned NREG_DEF  = 16;
  localparam int unsigned DW_DEF    = 32;
  localparam int unsigned DEPTH_DEF = 8;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/lock_queue.sv
module lock_queue #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = regbank_pkg::clog2_min1(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic [AW-1:0]        push_addr_i,
  input  logic                 pop_i,
  output logic [AW-1:0]        head_addr_o,
  output logic [CW-1:0]        count_o,
  output logic [DEPTH-1:0][AW-1:0] entry_addr_o,
  output logic [DEPTH-1:0]     entry_vld_o
);
  logic [DEPTH-1:0][AW-1:0] mem_q;
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;

  // entries presented in age order, index 0 = head
  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    logic [PW-1:0] slot;
    assign slot            = rd_ptr_q + PW'(i);
    assign entry_addr_o[i] = mem_q[slot];
    assign entry_vld_o[i]  = CW'(i) < cnt_q;
  end

  assign head_addr_o = mem_q[rd_ptr_q];
  assign count_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q    <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_ptr_q] <= push_addr_i;
        wr_ptr_q        <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      end
      if (pop_i) rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hazard_scan.sv
module hazard_scan #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DEPTH = 8
) (
  input  logic [DEPTH-1:0][AW-1:0] entry_addr_i,
  input  logic [DEPTH-1:0]         entry_vld_i,
  input  logic                     skip_head_i,
  input  logic [AW-1:0]            addr_a_i,
  input  logic [AW-1:0]            addr_b_i,
  output logic                     lock_a_o,
  output logic                     lock_b_o
);
  logic [DEPTH-1:0] live, hit_a, hit_b;

  // the head retiring this cycle no longer locks its register
  assign live = entry_vld_i & ~{{(DEPTH-1){1'b0}}, skip_head_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_a[i] = live[i] && (entry_addr_i[i] == addr_a_i);
    assign hit_b[i] = live[i] && (entry_addr_i[i] == addr_b_i);
  end

  assign lock_a_o = |hit_a;
  assign lock_b_o = |hit_b;
endmodule

// File: rtl/reg_array.sv
module reg_array #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = regbank_pkg::clog2_min1(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[r] <= '0;
      else if (we_i && waddr_i == AW'(r))   regs_q[r] <= wdata_i;
    end
  end

  // same-cycle write is visible to the read ports
  assign rdata_a_o = (we_i && waddr_i == raddr_a_i) ? wdata_i : regs_q[raddr_a_i];
  assign rdata_b_o = (we_i && waddr_i == raddr_b_i) ? wdata_i : regs_q[raddr_b_i];
endmodule

// File: rtl/regbank_wlq.sv
module regbank_wlq #(
  parameter int unsigned NREG  = regbank_pkg::NREG_DEF,
  parameter int unsigned DW    = regbank_pkg::DW_DEF,
  parameter int unsigned DEPTH = regbank_pkg::DEPTH_DEF,
  localparam int unsigned AW   = regbank_pkg::clog2_min1(NREG),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iss_valid_i,
  input  logic [AW-1:0] iss_ra_i,
  input  logic [AW-1:0] iss_rb_i,
  input  logic [AW-1:0] iss_rw_i,
  output logic          iss_ready_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  input  logic          wb_valid_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i
);
  logic [AW-1:0]               head_addr;
  logic [CW-1:0]               q_cnt;
  logic [DEPTH-1:0][AW-1:0]    entry_addr;
  logic [DEPTH-1:0]            entry_vld;
  logic                        wb_acc, iss_acc, room, lock_a, lock_b;
  logic [DW-1:0]               rdata_a, rdata_b;

  assign wb_acc      = wb_valid_i && (q_cnt != '0) && (wb_addr_i == head_addr);
  assign room        = (q_cnt != CW'(DEPTH)) || wb_acc;
  assign iss_ready_o = room && !lock_a && !lock_b;
  assign iss_acc     = iss_valid_i && iss_ready_o;

  lock_queue #(.AW(AW), .DEPTH(DEPTH)) queue_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (iss_acc),
    .push_addr_i  (iss_rw_i),
    .pop_i        (wb_acc),
    .head_addr_o  (head_addr),
    .count_o      (q_cnt),
    .entry_addr_o (entry_addr),
    .entry_vld_o  (entry_vld)
  );

  hazard_scan #(.AW(AW), .DEPTH(DEPTH)) scan_i (
    .entry_addr_i (entry_addr),
    .entry_vld_i  (entry_vld),
    .skip_head_i  (wb_acc),
    .addr_a_i     (iss_ra_i),
    .addr_b_i     (iss_rb_i),
    .lock_a_o     (lock_a),
    .lock_b_o     (lock_b)
  );

  reg_array #(.NREG(NREG), .DW(DW)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wb_acc),
    .waddr_i   (wb_addr_i),
    .wdata_i   (wb_data_i),
    .raddr_a_i (iss_ra_i),
    .raddr_b_i (iss_rb_i),
    .rdata_a_o (rdata_a),
    .rdata_b_o (rdata_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_a_o     <= '0;
      rd_b_o     <= '0;
    end else begin
      rd_valid_o <= iss_acc;
      if (iss_acc) begin
        rd_a_o <= rdata_a;
        rd_b_o <= rdata_b;
      end
    end
  end
endmodule

// File: rtl/regbank_wlq_chk.sv
module regbank_wlq_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          iss_valid_i,
  input logic          iss_ready_o,
  input logic          rd_valid_o,
  input logic          wb_acc_i,
  input logic [CW-1:0] cnt_i
);
  // R4
  rd_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && iss_ready_o) |=> rd_valid_o);
  // R4
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iss_valid_i && iss_ready_o) |=> !rd_valid_o);
  // R7
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));
  // R7
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CW'(DEPTH) && !wb_acc_i) |-> !iss_ready_o);
  // R6
  idle_queue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wb_acc_i && !(iss_valid_i && iss_ready_o)) |=> $stable(cnt_i));
  // R5
  pop_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_acc_i && !(iss_valid_i && iss_ready_o)) |=> cnt_i == $past(cnt_i) - 1'b1);
endmodule

bind regbank_wlq regbank_wlq_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_ready_o (iss_ready_o),
  .rd_valid_o  (rd_valid_o),
  .wb_acc_i    (wb_acc),
  .cnt_i       (q_cnt)
);

// File: tb/regbank_wlq_tb.sv
module regbank_wlq_tb_top;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        iss_valid_i = 1'b0;
  logic [3:0]  iss_ra_i = '0, iss_rb_i = '0, iss_rw_i = '0;
  logic        iss_ready_o, rd_valid_o;
  logic [31:0] rd_a_o, rd_b_o;
  logic        wb_valid_i = 1'b0;
  logic [3:0]  wb_addr_i = '0;
  logic [31:0] wb_data_i = '0;

  always #2.5 clk_i = ~clk_i;

  regbank_wlq dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] m_reg [16];
  logic [3:0]  mq [DEPTH];
  int          mcnt = 0;
  bit          exp_rv = 0;
  logic [31:0] exp_a = '0, exp_b = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit wb_taken(input bit wv, input logic [3:0] wa);
    return wv && mcnt > 0 && wa == mq[0];
  endfunction

  function automatic bit is_locked(input logic [3:0] r, input bit skip);
    for (int i = 0; i < mcnt; i++)
      if (!(skip && i == 0) && mq[i] == r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_ready(input logic [3:0] ra, input logic [3:0] rb, input bit wacc);
    bit room = (mcnt < DEPTH) || wacc;
    return room && !is_locked(ra, wacc) && !is_locked(rb, wacc);
  endfunction

  // called just after a falling edge
  task automatic cyc(input bit iv, input logic [3:0] ra, input logic [3:0] rb,
                     input logic [3:0] rw, input bit wv, input logic [3:0] wa,
                     input logic [31:0] wd, input string tag);
    bit wacc, rdy;
    iss_valid_i = iv; iss_ra_i = ra; iss_rb_i = rb; iss_rw_i = rw;
    wb_valid_i = wv; wb_addr_i = wa; wb_data_i = wd;
    #1;
    wacc = wb_taken(wv, wa);
    rdy  = exp_ready(ra, rb, wacc);
    check({tag, " ready"}, {31'b0, iss_ready_o}, {31'b0, rdy});
    @(posedge clk_i);
    exp_rv = iv && rdy;
    if (exp_rv) begin
      exp_a = (wacc && wa == ra) ? wd : m_reg[ra];
      exp_b = (wacc && wa == rb) ? wd : m_reg[rb];
    end
    if (wacc) begin
      m_reg[wa] = wd;
      for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (exp_rv) begin
      mq[mcnt] = rw;
      mcnt++;
    end
    @(negedge clk_i);
    check("R4 rd_valid", {31'b0, rd_valid_o}, {31'b0, exp_rv});
    if (exp_rv) begin
      check({tag, " R4 rd_a"}, rd_a_o, exp_a);
      check({tag, " R4 rd_b"}, rd_b_o, exp_b);
    end
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int r = 0; r < 16; r++) m_reg[r] = '0;
    for (int i = 0; i < DEPTH; i++) mq[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 ready", {31'b0, iss_ready_o}, 32'd1);
    check("R1 rd_valid", {31'b0, rd_valid_o}, 32'd0);
    cyc(1, 4'd0, 4'd15, 4'd5, 0, 4'd0, 32'h0, "R1");
    // R9 destination equals sources
    cyc(1, 4'd2, 4'd2, 4'd2, 0, 4'd0, 32'h0, "R9");
    // R3 duplicate lock on register 5
    cyc(1, 4'd0, 4'd1, 4'd5, 0, 4'd0, 32'h0, "R2");
    // R6 mismatched write-back, then read that register (R8 with writes pending)
    cyc(0, 4'd0, 4'd0, 4'd0, 1, 4'd9, 32'hdead_beef, "R6");
    cyc(1, 4'd9, 4'd9, 4'd1, 0, 4'd0, 32'h0, "R6 R8");
    // R3 first write of 5 retires, second still locks it
    cyc(1, 4'd5, 4'd0, 4'd3, 1, 4'd5, 32'h1111_aaaa, "R3");
    // R4 last lock of 2 retires with same-cycle read
    cyc(1, 4'd2, 4'd0, 4'd3, 1, 4'd2, 32'h2222_bbbb, "R4 R3");
    cyc(1, 4'd0, 4'd5, 4'd3, 1, 4'd5, 32'h3333_cccc, "R4 R3");
    // drain
    while (mcnt > 0) cyc(0, 4'd0, 4'd0, 4'd0, 1, mq[0], $urandom, "R5");
    // R6 write-back with empty queue
    cyc(0, 4'd0, 4'd0, 4'd0, 1, 4'd4, 32'hbad0_0001, "R6");
    cyc(1, 4'd4, 4'd4, 4'd6, 0, 4'd0, 32'h0, "R6");
    cyc(0, 4'd0, 4'd0, 4'd0, 1, 4'd6, 32'h6666_0000, "R5");
    // R7 fill the queue
    for (int k = 0; k < DEPTH; k++) cyc(1, 4'd1, 4'd1, 4'd7, 0, 4'd0, 32'h0, "R7");
    cyc(1, 4'd1, 4'd1, 4'd7, 0, 4'd0, 32'h0, "R7 full");
    cyc(1, 4'd1, 4'd1, 4'd7, 1, 4'd7, 32'h7777_0001, "R7 pop");
    while (mcnt > 0) cyc(0, 4'd0, 4'd0, 4'd0, 1, mq[0], $urandom, "R5");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit iv = ($urandom % 4) != 0;
      bit wv = ($urandom % 2) != 0;
      logic [3:0] wa = (mcnt > 0 && ($urandom % 5) != 0) ? mq[0] : 4'($urandom % 16);
      cyc(iv, 4'($urandom % 6), 4'($urandom % 6), 4'($urandom % 6), wv, wa, $urandom,
          "R2 R3 R5");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule